// File: doc/BRIEF.md
# Multiplexed Voltage-ID Pin Sequencer

This block sends a 6-bit voltage identification code to an external core supply regulator using only four pins. Three pins carry data. The fourth pin is a phase select, and its level tells the regulator which 3-bit half of the code is on the data pins.

A load strobe captures the code and the timing configuration. The block first shows the low half with the select pin low. After the configured hold time, it raises the select pin and shows the high half in the same cycle, and holds that for the same time. It then waits a settle period so the supply can reach the new level. At the end of the settle period it raises `done`. It also raises `ready`, which is meant to gate release of application activity.

All timing is counted in clock cycles. The hold time is clamped between a minimum and a maximum set as parameters. The settle wait is clamped between one cycle and a parameter maximum. The data pins change in the same cycle as the select edge, so the data setup delay after a select edge is zero cycles.

Top module: `vid_pin_sequencer`

## Requirements
- R1: While reset is asserted and until the first accepted load, `vid_sel` is 0, `vid_data` is 0, and `busy`, `done` and `ready` are 0.
- R2: In the cycle after a load is accepted, `vid_sel` is 0 and `vid_data` shows code bits [2:0]. This low phase lasts exactly the effective hold count in cycles.
- R3: When `vid_sel` rises, `vid_data` shows code bits [5:3] in the same cycle. Both pins then stay unchanged until the next accepted load.
- R4: The effective hold count equals `cfg_hold` clamped to the range [HOLD_MIN, HOLD_MAX]. The low phase and the high hold each last exactly this many cycles.
- R5: After the high hold, the block waits the effective settle count, which is `cfg_settle` clamped to [1, SETTLE_MAX]. `busy` is high for exactly 2×hold+settle cycles. It then falls in the same cycle that `done` rises.
- R6: `ready` stays 0 until `done` first rises. From then on it stays 1 until reset.
- R7: The code, `cfg_hold` and `cfg_settle` are captured on the accepted load. Later changes to these inputs have no effect on the pins or the timing of that sequence.
- R8: A load strobe that arrives while `busy` is 1 is ignored.
- R9: `vid_data` changes only in a cycle where `vid_sel` changes, or in the first cycle of a sequence. `busy` and `done` are never both 1, and `done` falls when the next load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 2*HALF_W | Voltage code to send |
| load | input | 1 | Starts a sequence when the block is not busy |
| cfg_hold | input | CNT_W | Requested per-phase hold, in cycles |
| cfg_settle | input | CNT_W | Requested settle wait, in cycles |
| vid_data | output | HALF_W | Data pins: one half of the code |
| vid_sel | output | 1 | Phase select: 0 = low half, 1 = high half |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished its settle wait |
| ready | output | 1 | Sticky: at least one sequence has completed |

## Verification
A wrong phase state shows at the pins within one cycle. Examples are a half on the wrong select level, a data change without a select edge, or a select edge arriving one cycle early or late. A wrong hold or settle counter shows as a low-phase length or a busy length that differs from the clamped configuration. That difference becomes visible when the phase ends, which is at most HOLD_MAX or SETTLE_MAX cycles after it began. A wrongly latched code or configuration shows when the halves captured at the select edges are rebuilt and compared with the loaded value.

// File: rtl/vid_pin_sequencer.sv
module vid_pin_sequencer #(
  parameter int HALF_W     = 3,
  parameter int CNT_W      = 24,
  parameter int HOLD_MIN   = 7000,
  parameter int HOLD_MAX   = 1000000,
  parameter int SETTLE_MAX = 1000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] code_in,
  input  logic                load,
  input  logic [CNT_W-1:0]    cfg_hold,
  input  logic [CNT_W-1:0]    cfg_settle,
  output logic [HALF_W-1:0]   vid_data,
  output logic                vid_sel,
  output logic                busy,
  output logic                done,
  output logic                ready
);
  localparam int CODE_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] HMIN = CNT_W'(HOLD_MIN);
  localparam logic [CNT_W-1:0] HMAX = CNT_W'(HOLD_MAX);
  localparam logic [CNT_W-1:0] SMAX = CNT_W'(SETTLE_MAX);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_SETTLE} state_t;

  state_t              st;
  logic [CODE_W-1:0]   code_q;
  logic [CNT_W-1:0]    hold_q, settle_q, cnt;
  logic [CNT_W-1:0]    hold_eff, settle_eff;
  logic                sel_q, done_q, ready_q;
  logic [HALF_W-1:0]   data_q;

  assign hold_eff   = (cfg_hold < HMIN) ? HMIN : (cfg_hold > HMAX) ? HMAX : cfg_hold;
  assign settle_eff = (cfg_settle == '0) ? ONE : (cfg_settle > SMAX) ? SMAX : cfg_settle;

  assign vid_data = data_q;
  assign vid_sel  = sel_q;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign ready    = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      code_q   <= '0;
      hold_q   <= '0;
      settle_q <= '0;
      cnt      <= '0;
      sel_q    <= 1'b0;
      data_q   <= '0;
      done_q   <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (load) begin
          code_q   <= code_in;
          hold_q   <= hold_eff;
          settle_q <= settle_eff;
          cnt      <= '0;
          sel_q    <= 1'b0;
          data_q   <= code_in[HALF_W-1:0];
          done_q   <= 1'b0;
          st       <= S_LO;
        end
        S_LO: if (cnt == hold_q - ONE) begin
          cnt    <= '0;
          sel_q  <= 1'b1;
          data_q <= code_q[CODE_W-1:HALF_W];
          st     <= S_HI;
        end else cnt <= cnt + ONE;
        S_HI: if (cnt == hold_q - ONE) begin
          cnt <= '0;
          st  <= S_SETTLE;
        end else cnt <= cnt + ONE;
        S_SETTLE: if (cnt == settle_q - ONE) begin
          cnt     <= '0;
          done_q  <= 1'b1;
          ready_q <= 1'b1;
          st      <= S_IDLE;
        end else cnt <= cnt + ONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vid_pin_sequencer_chk.sv
module vid_pin_sequencer_chk #(
  parameter int HALF_W   = 3,
  parameter int CNT_W    = 24,
  parameter int HOLD_MIN = 7000,
  parameter int HOLD_MAX = 1000000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load,
  input logic [HALF_W-1:0]   vid_data,
  input logic                vid_sel,
  input logic                busy,
  input logic                done,
  input logic                ready,
  input logic [2*HALF_W-1:0] code_q
);
  logic [CNT_W:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lo_run <= '0;
    else if (busy && !vid_sel) lo_run <= lo_run + 1'b1;
    else                     lo_run <= '0;
  end

  // R1
  reset_pins_chk: assert property (@(posedge clk)
    !rst_n |=> (!vid_sel && vid_data == '0 && !busy && !done && !ready));

  // R3
  hi_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_sel) |-> vid_data == code_q[2*HALF_W-1:HALF_W]);

  // R4
  lo_hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_sel) |-> (lo_run >= (CNT_W+1)'(HOLD_MIN) && lo_run <= (CNT_W+1)'(HOLD_MAX)));

  // R6
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> done);

  // R8
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> $stable(code_q));

  // R9
  data_moves_with_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vid_data) |-> (!$stable(vid_sel) || $rose(busy)));

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind vid_pin_sequencer vid_pin_sequencer_chk #(
  .HALF_W(HALF_W), .CNT_W(CNT_W), .HOLD_MIN(HOLD_MIN), .HOLD_MAX(HOLD_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .vid_data(vid_data), .vid_sel(vid_sel),
  .busy(busy), .done(done), .ready(ready), .code_q(code_q)
);

// File: tb/vid_pin_sequencer_bench.sv
module vid_pin_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 3;
  localparam int CW = 8;
  localparam int HM = 3;
  localparam int HX = 6;
  localparam int SX = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    code_in = '0;
  logic          load = 1'b0;
  logic [CW-1:0] cfg_hold = '0;
  logic [CW-1:0] cfg_settle = '0;
  logic [HW-1:0] vid_data;
  logic          vid_sel, busy, done, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit first_seq = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_pin_sequencer #(.HALF_W(HW), .CNT_W(CW), .HOLD_MIN(HM), .HOLD_MAX(HX), .SETTLE_MAX(SX))
  u_vid_pin_sequencer (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .load(load), .cfg_hold(cfg_hold),
    .cfg_settle(cfg_settle), .vid_data(vid_data), .vid_sel(vid_sel), .busy(busy),
    .done(done), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int clamp_h(input int v);
    return (v < HM) ? HM : (v > HX) ? HX : v;
  endfunction

  function automatic int clamp_s(input int v);
    return (v == 0) ? 1 : (v > SX) ? SX : v;
  endfunction

  task automatic run_seq(input int code, input int hold, input int settle, input bit inject);
    int eh, es, lo, hi, n, lo_d, hi_d, rebuilt;
    bit lo_bad, hi_bad, rdy_bad;
    eh = clamp_h(hold);
    es = clamp_s(settle);
    @(negedge clk);
    code_in = 6'(code); cfg_hold = CW'(hold); cfg_settle = CW'(settle); load = 1'b1;
    @(negedge clk);
    load = 1'b0; code_in = ~6'(code); cfg_hold = '1; cfg_settle = '0;
    chk(busy === 1'b1 && done === 1'b0, "R9 busy/done at start", {busy, done}, 2);
    chk(vid_sel === 1'b0 && vid_data === 3'(code), "R2 low half first cycle", vid_data, code & 7);
    lo = 0; hi = 0; n = 0; lo_d = -1; hi_d = -1; lo_bad = 0; hi_bad = 0; rdy_bad = 0;
    while (busy === 1'b1 && n < 200) begin
      if (first_seq && ready !== 1'b0) rdy_bad = 1;
      if (!first_seq && ready !== 1'b1) rdy_bad = 1;
      if (vid_sel === 1'b0) begin
        if (hi > 0) lo_bad = 1;
        if (lo_d < 0) lo_d = int'(vid_data); else if (int'(vid_data) != lo_d) lo_bad = 1;
        lo++;
      end else begin
        if (hi_d < 0) hi_d = int'(vid_data); else if (int'(vid_data) != hi_d) hi_bad = 1;
        hi++;
      end
      if (inject && n == 1) begin load = 1'b1; code_in = 6'(code) ^ 6'h2A; end
      else load = 1'b0;
      n++;
      @(negedge clk);
    end
    load = 1'b0;
    rebuilt = (hi_d << 3) | lo_d;
    chk(lo_d == (code & 7) && !lo_bad, "R2 low half value", lo_d, code & 7);
    chk(lo == eh, "R4 low phase length", lo, eh);
    chk(lo >= HM && lo <= HX, "R4 hold in window", lo, eh);
    chk(hi_d == (code >> 3) && !hi_bad, "R3 high half value", hi_d, code >> 3);
    chk(hi == eh + es, "R5 high hold plus settle", hi, eh + es);
    chk(done === 1'b1 && busy === 1'b0, "R5 done after settle", {busy, done}, 1);
    chk(!rdy_bad, first_seq ? "R6 ready low before first done" : "R6 ready held", rdy_bad, 0);
    chk(ready === 1'b1, "R6 ready after done", ready, 1);
    chk(rebuilt == code, inject ? "R8 busy load ignored" : "R7 code latched", rebuilt, code);
    first_seq = 0;
    @(negedge clk);
    chk(vid_sel === 1'b1 && int'(vid_data) == (code >> 3) && done === 1'b1,
        "R3 pins static after done", vid_data, code >> 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vid_sel === 1'b0 && vid_data === '0 && busy === 1'b0 && done === 1'b0 && ready === 1'b0,
        "R1 reset state", {vid_sel, vid_data, busy, done, ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(vid_sel === 1'b0 && vid_data === '0 && ready === 1'b0, "R1 idle before load",
        {vid_sel, vid_data, ready}, 0);
    for (int c = 0; c < 64; c++) run_seq(c, c % 9, (c * 7) % 13, (c % 3) == 0);
    for (int h = 0; h < 9; h++) run_seq(6'h35 ^ h, h, 11, 1'b0);
    summary();
  end
endmodule